// File: doc/BRIEF.md
# Card Presence and Event Notifier

This block watches a removable-card slot and tells the rest of the system when a card arrives or leaves. Presence is taken from a dedicated detect pin, whose active level is programmable, from the card's DATA3 line, or from both at once. Both inputs are first synchronised. An optional filter can then require the chosen level to hold for a long stretch before the presence state changes.

Every change of the filtered presence state raises an interrupt and records a wake event. The interrupt is either held until software acknowledges it (level mode) or sent as a short pulse (pulse mode). Each mode has its own polarity bit. The wake event sets a sticky status bit. It also drives an active-low wake pulse, but only when both the global and the per-slot wake enables are on. The block can also force DATA3 to be an output at a chosen level.

Software reaches two control bytes and one write-one-to-clear status byte through a small register port.

Top module: `cdet_evt_unit`

## Requirements
- R1: After reset, control byte A (address 0) reads 01h, control byte B (address 1) reads 01h and status (address 2) reads 00h. In this state wake_n is 1, irq_out is 0, dat3_oe is 0 and card_present is 0.
- R2: Control A bit 1 selects the detect pin as a source. Control A bit 2 sets the pin's polarity: 0 means a low pin is a present card, 1 means a high pin is a present card.
- R3: Control A bit 0 selects DATA3 as a source, and a high DATA3 is a present card. DATA3 is ignored as a source while control A bit 4 forces it to be an output, and it is also ignored when bit 0 is clear.
- R4: When both sources are selected, the card is present if either source reports present. When neither source is selected, the card is not present.
- R5: With control B bit 0 set, card_present changes only after the selected level has differed from it for 2^DEB_LOG2 consecutive cycles, so shorter glitches are ignored. With bit 0 clear, card_present follows an input change on the third rising edge.
- R6: Each change of card_present sets status bit 1 (wake event) one cycle later. In level mode it also sets status bit 0 (interrupt pending). Writing 1 to a status bit clears it.
- R7: In level mode (control B bit 1 = 0), irq_out shows interrupt pending. Control B bit 3 sets the polarity: 0 is active high, 1 is active low.
- R8: In pulse mode (control B bit 1 = 1), each presence change drives irq_out active for 4 cycles, starting one cycle after card_present changes, and status bit 0 is not set. Control B bit 2 sets the polarity: 1 is active high, 0 is active low.
- R9: wake_n goes low for 4 cycles after a presence change only when wake_en_glb and wake_en_ifc are both 1. Otherwise it stays high.
- R10: Control A bit 4 makes dat3_oe 1 and dat3_out equal to control A bit 5. With bit 4 clear, dat3_oe is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address: 0 control A, 1 control B, 2 status |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr |
| det_pin | input | 1 | Dedicated card-detect pin (asynchronous) |
| dat3_in | input | 1 | DATA3 line level (asynchronous) |
| dat3_oe | output | 1 | DATA3 output enable |
| dat3_out | output | 1 | DATA3 driven level |
| wake_en_glb | input | 1 | Global wake enable |
| wake_en_ifc | input | 1 | Per-slot wake enable |
| card_present | output | 1 | Filtered card presence |
| irq_out | output | 1 | Interrupt output, polarity per mode |
| wake_n | output | 1 | Active-low wake pulse |

## Verification
The hardest case to reach is the debounce boundary. The presence state must stay unchanged one cycle before the filter window closes and must flip exactly on the last cycle. A glitch shorter than the window must leave no trace, not even a pending event. The bench shortens the window through the DEB_LOG2 parameter. It then holds DATA3 at a new level for exactly the window length plus the synchroniser delay, probing one cycle before and at the expected flip. After that it applies a ten-cycle reversal and confirms that both the status and the presence state stay unchanged.

// File: rtl/cdet_pkg.sv
package cdet_pkg;

    // Control byte A: source selection, pin polarity, DATA3 drive
    typedef struct packed {
        logic [1:0] spare_hi;
        logic       d3_level;
        logic       d3_force;
        logic       spare_mid;
        logic       pin_pol;
        logic       pin_sel;
        logic       d3_sel;
    } ctl_a_t;

    // Control byte B: filter and interrupt shape
    typedef struct packed {
        logic [3:0] spare_hi;
        logic       lvl_act_low;
        logic       pls_act_high;
        logic       pulse_mode;
        logic       deb_en;
    } ctl_b_t;

    typedef enum logic [1:0] {
        ADDR_CTL_A  = 2'd0,
        ADDR_CTL_B  = 2'd1,
        ADDR_STATUS = 2'd2,
        ADDR_NONE   = 2'd3
    } reg_addr_e;

    localparam logic [7:0] CTL_A_RST = 8'h01;
    localparam logic [7:0] CTL_B_RST = 8'h01;
    localparam int STS_IRQ_BIT  = 0;
    localparam int STS_WAKE_BIT = 1;

    // Pin level to presence: pol 0 -> low means present, pol 1 -> high means present
    function automatic logic pin_to_present(input logic lvl, input logic pol);
        return ~(lvl ^ pol);
    endfunction

    // Drive an active flag with the chosen polarity
    function automatic logic polarize(input logic active, input logic act_high);
        return act_high ? active : ~active;
    endfunction

endpackage

// File: rtl/cdet_regs.sv
module cdet_regs
    import cdet_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       wr,
    input  logic [1:0] addr,
    input  logic [7:0] wdata,
    input  logic       sts_irq,
    input  logic       sts_wake,
    output ctl_a_t     ctl_a,
    output ctl_b_t     ctl_b,
    output logic       clr_irq,
    output logic       clr_wake,
    output logic [7:0] rdata
);
    reg_addr_e sel;
    assign sel = reg_addr_e'(addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_a <= ctl_a_t'(CTL_A_RST);
            ctl_b <= ctl_b_t'(CTL_B_RST);
        end else if (wr) begin
            if (sel == ADDR_CTL_A) ctl_a <= ctl_a_t'(wdata);
            if (sel == ADDR_CTL_B) ctl_b <= ctl_b_t'(wdata);
        end
    end

    assign clr_irq  = wr && (sel == ADDR_STATUS) && wdata[STS_IRQ_BIT];
    assign clr_wake = wr && (sel == ADDR_STATUS) && wdata[STS_WAKE_BIT];

    always_comb begin
        rdata = 8'h00;
        case (sel)
            ADDR_CTL_A:  rdata = ctl_a;
            ADDR_CTL_B:  rdata = ctl_b;
            ADDR_STATUS: begin
                rdata[STS_IRQ_BIT]  = sts_irq;
                rdata[STS_WAKE_BIT] = sts_wake;
            end
            default:     rdata = 8'h00;
        endcase
    end
endmodule

// File: rtl/cdet_src.sv
module cdet_src
    import cdet_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic det_pin,
    input  logic dat3_in,
    input  logic pin_sel,
    input  logic pin_pol,
    input  logic d3_sel,
    input  logic d3_force,
    output logic raw_present
);
    localparam int NUM_IN = 2;

    logic [NUM_IN-1:0] async_in;
    logic [NUM_IN-1:0] synced;

    assign async_in = {dat3_in, det_pin};

    for (genvar k = 0; k < NUM_IN; k++) begin : g_sync
        logic [SYNC_STAGES-1:0] shreg;
        always_ff @(posedge clk) begin
            if (rst) shreg <= '0;
            else     shreg <= {shreg[SYNC_STAGES-2:0], async_in[k]};
        end
        assign synced[k] = shreg[SYNC_STAGES-1];
    end

    logic pin_vote;
    logic d3_vote;

    assign pin_vote    = pin_sel & pin_to_present(synced[0], pin_pol);
    assign d3_vote     = d3_sel & ~d3_force & synced[1];
    assign raw_present = pin_vote | d3_vote;
endmodule

// File: rtl/cdet_debounce.sv
module cdet_debounce #(
    parameter int DEB_LOG2 = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    input  logic deb_en,
    output logic present,
    output logic chg
);
    localparam logic [DEB_LOG2-1:0] CNT_MAX = {DEB_LOG2{1'b1}};

    logic [DEB_LOG2-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            present <= 1'b0;
            chg     <= 1'b0;
            cnt     <= '0;
        end else begin
            chg <= 1'b0;
            if (!deb_en) begin
                cnt <= '0;
                if (raw != present) begin
                    present <= raw;
                    chg     <= 1'b1;
                end
            end else if (raw == present) begin
                cnt <= '0;
            end else if (cnt == CNT_MAX) begin
                present <= raw;
                chg     <= 1'b1;
                cnt     <= '0;
            end else begin
                cnt <= cnt + 1'b1;
            end
        end
    end
endmodule

// File: rtl/cdet_pulse.sv
module cdet_pulse #(
    parameter int LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic fire,
    output logic active
);
    localparam int CW = $clog2(LEN + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst)             cnt <= '0;
        else if (fire)       cnt <= CW'(LEN);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign active = (cnt != '0);
endmodule

// File: rtl/cdet_event.sv
module cdet_event
    import cdet_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic chg,
    input  logic pulse_mode,
    input  logic pls_act_high,
    input  logic lvl_act_low,
    input  logic clr_irq,
    input  logic clr_wake,
    input  logic wake_en_glb,
    input  logic wake_en_ifc,
    output logic irq_pend,
    output logic wake_sts,
    output logic irq_out,
    output logic wake_n
);
    logic irq_fire;
    logic wake_fire;
    logic irq_pulse;
    logic wake_pulse;

    assign irq_fire  = chg & pulse_mode;
    assign wake_fire = chg & wake_en_glb & wake_en_ifc;

    always_ff @(posedge clk) begin
        if (rst) begin
            irq_pend <= 1'b0;
            wake_sts <= 1'b0;
        end else begin
            if (chg && !pulse_mode) irq_pend <= 1'b1;
            else if (clr_irq)       irq_pend <= 1'b0;
            if (chg)                wake_sts <= 1'b1;
            else if (clr_wake)      wake_sts <= 1'b0;
        end
    end

    cdet_pulse #(.LEN(PULSE_LEN)) u_irq_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (irq_fire),
        .active (irq_pulse)
    );

    cdet_pulse #(.LEN(PULSE_LEN)) u_wake_pulse (
        .clk    (clk),
        .rst    (rst),
        .fire   (wake_fire),
        .active (wake_pulse)
    );

    assign irq_out = pulse_mode ? polarize(irq_pulse, pls_act_high)
                                : polarize(irq_pend, ~lvl_act_low);
    assign wake_n  = ~wake_pulse;
endmodule

// File: rtl/cdet_evt_unit.sv
module cdet_evt_unit
    import cdet_pkg::*;
#(
    parameter int DEB_LOG2    = 16,
    parameter int PULSE_LEN   = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       reg_wr,
    input  logic [1:0] reg_addr,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    input  logic       det_pin,
    input  logic       dat3_in,
    output logic       dat3_oe,
    output logic       dat3_out,
    input  logic       wake_en_glb,
    input  logic       wake_en_ifc,
    output logic       card_present,
    output logic       irq_out,
    output logic       wake_n
);
    ctl_a_t ctl_a;
    ctl_b_t ctl_b;
    logic   clr_irq;
    logic   clr_wake;
    logic   irq_pend;
    logic   wake_sts;
    logic   raw_present;
    logic   evt_chg;

    cdet_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr       (reg_wr),
        .addr     (reg_addr),
        .wdata    (reg_wdata),
        .sts_irq  (irq_pend),
        .sts_wake (wake_sts),
        .ctl_a    (ctl_a),
        .ctl_b    (ctl_b),
        .clr_irq  (clr_irq),
        .clr_wake (clr_wake),
        .rdata    (reg_rdata)
    );

    cdet_src #(.SYNC_STAGES(SYNC_STAGES)) u_src (
        .clk         (clk),
        .rst         (rst),
        .det_pin     (det_pin),
        .dat3_in     (dat3_in),
        .pin_sel     (ctl_a.pin_sel),
        .pin_pol     (ctl_a.pin_pol),
        .d3_sel      (ctl_a.d3_sel),
        .d3_force    (ctl_a.d3_force),
        .raw_present (raw_present)
    );

    cdet_debounce #(.DEB_LOG2(DEB_LOG2)) u_deb (
        .clk     (clk),
        .rst     (rst),
        .raw     (raw_present),
        .deb_en  (ctl_b.deb_en),
        .present (card_present),
        .chg     (evt_chg)
    );

    cdet_event #(.PULSE_LEN(PULSE_LEN)) u_evt (
        .clk          (clk),
        .rst          (rst),
        .chg          (evt_chg),
        .pulse_mode   (ctl_b.pulse_mode),
        .pls_act_high (ctl_b.pls_act_high),
        .lvl_act_low  (ctl_b.lvl_act_low),
        .clr_irq      (clr_irq),
        .clr_wake     (clr_wake),
        .wake_en_glb  (wake_en_glb),
        .wake_en_ifc  (wake_en_ifc),
        .irq_pend     (irq_pend),
        .wake_sts     (wake_sts),
        .irq_out      (irq_out),
        .wake_n       (wake_n)
    );

    assign dat3_oe  = ctl_a.d3_force;
    assign dat3_out = ctl_a.d3_level;
endmodule

// File: rtl/cdet_evt_chk.sv
module cdet_evt_chk #(
    parameter int PULSE_LEN = 4
) (
    input logic clk,
    input logic rst,
    input logic wake_n,
    input logic wake_en_glb,
    input logic wake_en_ifc,
    input logic evt_chg,
    input logic irq_pend,
    input logic wake_sts,
    input logic clr_irq,
    input logic clr_wake,
    input logic pulse_mode
);
    localparam int SW = $clog2(PULSE_LEN + 2);

    logic [SW-1:0] since_fire;

    always_ff @(posedge clk) begin
        if (rst)                                       since_fire <= SW'(PULSE_LEN);
        else if (evt_chg && wake_en_glb && wake_en_ifc) since_fire <= '0;
        else if (since_fire < SW'(PULSE_LEN))           since_fire <= since_fire + 1'b1;
    end

    AST_WAKE_GATED: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_n) |-> $past(evt_chg && wake_en_glb && wake_en_ifc)); // R9
    AST_WAKE_WINDOW: assert property (@(posedge clk) disable iff (rst)
        !wake_n |-> (since_fire < SW'(PULSE_LEN))); // R9
    AST_PEND_SOURCE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq_pend) |-> $past(evt_chg && !pulse_mode)); // R8
    AST_PEND_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(irq_pend) |-> $past(clr_irq)); // R6
    AST_WAKE_STS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $fell(wake_sts) |-> $past(clr_wake)); // R6
    AST_WAKE_STS_SET: assert property (@(posedge clk) disable iff (rst)
        evt_chg |=> wake_sts); // R6
endmodule

bind cdet_evt_unit cdet_evt_chk #(.PULSE_LEN(PULSE_LEN)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .wake_n      (wake_n),
    .wake_en_glb (wake_en_glb),
    .wake_en_ifc (wake_en_ifc),
    .evt_chg     (evt_chg),
    .irq_pend    (irq_pend),
    .wake_sts    (wake_sts),
    .clr_irq     (clr_irq),
    .clr_wake    (clr_wake),
    .pulse_mode  (ctl_b.pulse_mode)
);

// File: tb/cdet_evt_unit_tb.sv
module cdet_evt_unit_tb;
    localparam int DEB_LOG2 = 4;
    localparam int WINDOW   = 1 << DEB_LOG2;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic [7:0] reg_wdata = 8'h00;
    logic [7:0] reg_rdata;
    logic       det_pin = 1'b0;
    logic       dat3_in = 1'b0;
    logic       dat3_oe;
    logic       dat3_out;
    logic       wake_en_glb = 1'b0;
    logic       wake_en_ifc = 1'b0;
    logic       card_present;
    logic       irq_out;
    logic       wake_n;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #4 clk = ~clk;

    cdet_evt_unit #(.DEB_LOG2(DEB_LOG2)) u_dut (
        .clk          (clk),
        .rst          (rst),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .det_pin      (det_pin),
        .dat3_in      (dat3_in),
        .dat3_oe      (dat3_oe),
        .dat3_out     (dat3_out),
        .wake_en_glb  (wake_en_glb),
        .wake_en_ifc  (wake_en_ifc),
        .card_present (card_present),
        .irq_out      (irq_out),
        .wake_n       (wake_n)
    );

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string what);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        reg_wr    = 1'b1;
        reg_addr  = a;
        reg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic quiesce(input logic [7:0] a, input logic [7:0] b, input logic pin, input logic d3);
        det_pin = pin;
        dat3_in = d3;
        wr(2'd0, a);
        wr(2'd1, b);
        step(2 * WINDOW + 8);
        wr(2'd2, 8'h03);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd(2'd0, d); chk(d, 8'h01, "R1 control A reset");
        rd(2'd1, d); chk(d, 8'h01, "R1 control B reset");
        rd(2'd2, d); chk(d, 8'h00, "R1 status reset");
        chk(wake_n, 1'b1, "R1 wake_n idle");
        chk(irq_out, 1'b0, "R1 irq idle");
        chk(dat3_oe, 1'b0, "R1 DATA3 not driven");
        chk(card_present, 1'b0, "R1 no card");
    endtask

    task automatic t_debounce();
        logic [7:0] d;
        dat3_in = 1'b1;
        step(WINDOW + 1);
        chk(card_present, 1'b0, "R5 filter holds one cycle early");
        step(1);
        chk(card_present, 1'b1, "R5 filter flips at window end");
        step(1);
        rd(2'd2, d); chk(d, 8'h03, "R6 insertion sets both status bits");
        chk(irq_out, 1'b1, "R7 level irq active high");
        wr(2'd2, 8'h03);
        rd(2'd2, d); chk(d, 8'h00, "R6 write one clears status");
        chk(irq_out, 1'b0, "R7 irq released after clear");
        dat3_in = 1'b0;
        step(10);
        dat3_in = 1'b1;
        step(2 * WINDOW);
        chk(card_present, 1'b1, "R5 short glitch ignored");
        rd(2'd2, d); chk(d, 8'h00, "R5 glitch raises no event");
    endtask

    task automatic t_latency();
        logic [7:0] d;
        quiesce(8'h01, 8'h00, 1'b0, 1'b1);
        dat3_in = 1'b0;
        step(2);
        chk(card_present, 1'b1, "R5 no change before third edge");
        step(1);
        chk(card_present, 1'b0, "R5 unfiltered change on third edge");
        step(1);
        rd(2'd2, d); chk(d, 8'h03, "R6 removal sets status");
    endtask

    task automatic t_level_pol();
        logic [7:0] d;
        quiesce(8'h01, 8'h08, 1'b0, 1'b0);
        chk(irq_out, 1'b1, "R7 active-low idle level");
        dat3_in = 1'b1;
        step(4);
        chk(irq_out, 1'b0, "R7 active-low asserted");
        wr(2'd2, 8'h01);
        chk(irq_out, 1'b1, "R7 active-low released by clear");
        rd(2'd2, d); chk(d, 8'h02, "R6 wake status kept after irq clear");
        wr(2'd2, 8'h02);
        rd(2'd2, d); chk(d, 8'h00, "R6 wake status cleared");
    endtask

    task automatic t_pulse();
        logic [7:0] d;
        quiesce(8'h01, 8'h06, 1'b0, 1'b1);
        chk(irq_out, 1'b0, "R8 pulse active-high idle");
        dat3_in = 1'b0;
        step(3);
        chk(irq_out, 1'b0, "R8 no pulse before event");
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk(irq_out, 1'b1, "R8 pulse cycle active");
            chk(wake_n, 1'b1, "R9 no wake with enables off");
        end
        step(1);
        chk(irq_out, 1'b0, "R8 pulse ends after four cycles");
        rd(2'd2, d); chk(d, 8'h02, "R8 no pending bit in pulse mode");
        wr(2'd1, 8'h02);
        chk(irq_out, 1'b1, "R8 pulse active-low idle");
    endtask

    task automatic t_wake();
        int lows;
        wake_en_glb = 1'b1;
        wake_en_ifc = 1'b1;
        quiesce(8'h01, 8'h00, 1'b0, 1'b0);
        dat3_in = 1'b1;
        step(3);
        chk(wake_n, 1'b1, "R9 wake idle before event");
        for (int i = 0; i < 4; i++) begin
            step(1);
            chk(wake_n, 1'b0, "R9 wake pulse low");
        end
        step(1);
        chk(wake_n, 1'b1, "R9 wake pulse four cycles");
        wake_en_ifc = 1'b0;
        dat3_in = 1'b0;
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (wake_n == 1'b0) lows++;
        end
        chk(8'(lows), 8'd0, "R9 slot enable off blocks wake");
        wake_en_glb = 1'b0;
        wake_en_ifc = 1'b1;
        dat3_in = 1'b1;
        lows = 0;
        for (int i = 0; i < 10; i++) begin
            step(1);
            if (wake_n == 1'b0) lows++;
        end
        chk(8'(lows), 8'd0, "R9 global enable off blocks wake");
        wake_en_ifc = 1'b0;
    endtask

    task automatic t_pin();
        quiesce(8'h02, 8'h00, 1'b1, 1'b1);
        chk(card_present, 1'b0, "R3 unselected DATA3 ignored, pin high absent");
        det_pin = 1'b0;
        step(3);
        chk(card_present, 1'b1, "R2 low pin present with polarity 0");
        wr(2'd0, 8'h06);
        step(2);
        chk(card_present, 1'b0, "R2 low pin absent with polarity 1");
        det_pin = 1'b1;
        step(3);
        chk(card_present, 1'b1, "R2 high pin present with polarity 1");
    endtask

    task automatic t_both();
        quiesce(8'h03, 8'h00, 1'b1, 1'b0);
        chk(card_present, 1'b0, "R4 both sources absent");
        dat3_in = 1'b1;
        step(3);
        chk(card_present, 1'b1, "R4 DATA3 alone present");
        dat3_in = 1'b0;
        det_pin = 1'b0;
        step(3);
        chk(card_present, 1'b1, "R4 pin alone present");
        det_pin = 1'b1;
        step(3);
        chk(card_present, 1'b0, "R4 neither present");
        quiesce(8'h00, 8'h00, 1'b0, 1'b1);
        chk(card_present, 1'b0, "R4 no source selected");
    endtask

    task automatic t_drive();
        quiesce(8'h31, 8'h00, 1'b0, 1'b1);
        chk(dat3_oe, 1'b1, "R10 DATA3 driven");
        chk(dat3_out, 1'b1, "R10 DATA3 driven high");
        chk(card_present, 1'b0, "R3 forced DATA3 ignored as source");
        wr(2'd0, 8'h11);
        chk(dat3_out, 1'b0, "R10 DATA3 driven low");
        wr(2'd0, 8'h01);
        chk(dat3_oe, 1'b0, "R10 DATA3 released");
        step(2);
        chk(card_present, 1'b1, "R3 DATA3 source resumes");
    endtask

    initial begin
        step(5);
        rst = 1'b0;
        step(1);
        t_reset();
        t_debounce();
        t_latency();
        t_level_pol();
        t_pulse();
        t_wake();
        t_pin();
        t_both();
        t_drive();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule